// File: doc/BRIEF.md
# Security-Banked Interrupt Control and State Register

This block is the interrupt control and state word of a small interrupt controller that serves two security states. It sits at one address of the system control space. A read returns four things: the active exception number, the highest pending exception number, a flag that is set when the core will return to base level, and the pending flags of the timer-tick, deferred-service and NMI exceptions. The timer-tick and deferred-service flags are held once per security state. The `secure_i` attribute of the access chooses which copy a read shows and which copy a write changes.

NMI pending is a single flag. It can be seen and written through the bus only while the configuration input that hands bus-fault, hard-fault and NMI to the non-secure state is high. Software can also clear NMI pending, but only when the newer-architecture mode input is high as well. The exception tracking logic drives set lines (timer and NMI sources) and acknowledge lines (exception entry) into the block, and it reads the pending flags back from the block's outputs.

Top module: `sec_icsr`

## Requirements
- R1: While `rst_ni` is low, every pending flag and `rdata_o` are 0.
- R2: A read at offset `REG_OFS` returns the active number in bits [8:0] and the pending number in bits [20:12]. Bit 11 is set only when `num_active_i` equals 1. The word appears on `rdata_o` one clock after the access. Any other cycle, including a read at another offset, gives 0.
- R3: Bit 26 reads as timer-tick pending and bit 28 reads as deferred-service pending. Both come from the secure copy (index 1) when `secure_i` is 1 and from the non-secure copy (index 0) when it is 0.
- R4: Bit 31 reads as NMI pending when `nmi_to_ns_i` is 1, and reads 0 when it is 0.
- R5: Bits 21 to 25, 27, 29 and 30 always read 0. This covers the preempt status bit and the non-secure tick-target bit.
- R6: A write with bit 28 set sets deferred-service pending in the accessing copy, and a write with bit 27 set clears it. If both bits are set in one write, nothing changes.
- R7: A write with bit 26 set sets timer-tick pending in the accessing copy, and a write with bit 25 set clears it. If both bits are set in one write, nothing changes.
- R8: A write with bit 31 set sets NMI pending, but only when `nmi_to_ns_i` is 1.
- R9: A write with bit 30 set and bit 31 clear clears NMI pending, but only when both `nmi_to_ns_i` and `v8_mode_i` are 1.
- R10: Written bits other than 25 to 28, 30 and 31 have no effect. Writes at other offsets and all reads leave the pending state unchanged.
- R11: The hardware set lines set their flags and the acknowledge lines clear them. A set from any source wins over a clear from any source in the same cycle. All pending updates take effect on the clock edge of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| addr_i | input | ADDR_W | Byte offset in the system control space |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Security attribute of the access |
| rdata_o | output | 32 | Registered read data |
| nmi_to_ns_i | input | 1 | Configuration: fault and NMI handling handed to non-secure |
| v8_mode_i | input | 1 | Newer-architecture mode enable |
| active_vec_i | input | VEC_W | Active exception number |
| pend_vec_i | input | VEC_W | Highest pending exception number |
| num_active_i | input | CNT_W | Number of active exceptions |
| hw_tick_set_i | input | 2 | Timer-tick set per copy (1 = secure) |
| hw_nmi_set_i | input | 1 | NMI set from hardware |
| ack_tick_i | input | 2 | Timer-tick clear on entry, per copy |
| ack_sv_i | input | 2 | Deferred-service clear on entry, per copy |
| ack_nmi_i | input | 1 | NMI clear on entry |
| pend_tick_o | output | 2 | Timer-tick pending per copy |
| pend_sv_o | output | 2 | Deferred-service pending per copy |
| pend_nmi_o | output | 1 | NMI pending |

## Verification
The hardest cases to reach from the ports are the collisions: a software clear and a hardware set of the same flag landing on one edge, and one write that carries both a set bit and its clear bit. The stimulus reaches them by raising a hardware set line in the same cycle as a clearing bus write, and by writing words with both bits of a pair set. The flags are then read back through the pending outputs and through the bus, in both security states. The pending state is walked step by step through a vector table so that each write starts from a known mix of secure and non-secure flags.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned B_RET_BASE = 11;
  localparam int unsigned B_TICK_CLR = 25;
  localparam int unsigned B_TICK     = 26;
  localparam int unsigned B_SV_CLR   = 27;
  localparam int unsigned B_SV       = 28;
  localparam int unsigned B_NMI_CLR  = 30;
  localparam int unsigned B_NMI      = 31;
  localparam int unsigned FLD_W      = 9;
  localparam int unsigned PVEC_LSB   = 12;

  localparam logic [DW-1:0] RSV_MASK = 32'h6BE0_0000;

  typedef struct packed {
    logic tick_set;
    logic tick_clr;
    logic sv_set;
    logic sv_clr;
    logic nmi_set;
    logic nmi_clr;
  } wr_cmd_t;
endpackage

// File: rtl/icsr_wr_dec.sv
module icsr_wr_dec
  import icsr_pkg::*;
(
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          nmi_to_ns_i,
  input  logic          v8_mode_i,
  output wr_cmd_t       cmd_o
);
  // a set bit together with its clear bit cancels both
  always_comb begin
    cmd_o.tick_set = wr_i &  wdata_i[B_TICK]   & ~wdata_i[B_TICK_CLR];
    cmd_o.tick_clr = wr_i & ~wdata_i[B_TICK]   &  wdata_i[B_TICK_CLR];
    cmd_o.sv_set   = wr_i &  wdata_i[B_SV]     & ~wdata_i[B_SV_CLR];
    cmd_o.sv_clr   = wr_i & ~wdata_i[B_SV]     &  wdata_i[B_SV_CLR];
    cmd_o.nmi_set  = wr_i & nmi_to_ns_i & wdata_i[B_NMI];
    cmd_o.nmi_clr  = wr_i & nmi_to_ns_i & v8_mode_i
                   & wdata_i[B_NMI_CLR] & ~wdata_i[B_NMI];
  end
endmodule

// File: rtl/icsr_pend_bit.sv
module icsr_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/icsr_rd_mux.sv
module icsr_rd_mux
  import icsr_pkg::*;
#(
  parameter int unsigned VEC_W = 9,
  parameter int unsigned CNT_W = 4
) (
  input  logic [VEC_W-1:0] active_vec_i,
  input  logic [VEC_W-1:0] pend_vec_i,
  input  logic [CNT_W-1:0] num_active_i,
  input  logic [1:0]       tick_i,
  input  logic [1:0]       sv_i,
  input  logic             nmi_i,
  input  logic             secure_i,
  input  logic             nmi_to_ns_i,
  output logic [DW-1:0]    word_o
);
  logic [FLD_W-1:0] act_f, pend_f;

  always_comb begin
    act_f  = FLD_W'(active_vec_i);
    pend_f = FLD_W'(pend_vec_i);
    word_o = '0;
    word_o[FLD_W-1:0]                 = act_f;
    word_o[PVEC_LSB+FLD_W-1:PVEC_LSB] = pend_f;
    word_o[B_RET_BASE] = (num_active_i == CNT_W'(1));
    word_o[B_TICK]     = secure_i ? tick_i[1] : tick_i[0];
    word_o[B_SV]       = secure_i ? sv_i[1]   : sv_i[0];
    word_o[B_NMI]      = nmi_to_ns_i & nmi_i;
  end
endmodule

// File: rtl/sec_icsr.sv
module sec_icsr
  import icsr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'hD04,
  parameter int unsigned VEC_W   = 9,
  parameter int unsigned CNT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              secure_i,
  output logic [31:0]       rdata_o,
  input  logic              nmi_to_ns_i,
  input  logic              v8_mode_i,
  input  logic [VEC_W-1:0]  active_vec_i,
  input  logic [VEC_W-1:0]  pend_vec_i,
  input  logic [CNT_W-1:0]  num_active_i,
  input  logic [1:0]        hw_tick_set_i,
  input  logic              hw_nmi_set_i,
  input  logic [1:0]        ack_tick_i,
  input  logic [1:0]        ack_sv_i,
  input  logic              ack_nmi_i,
  output logic [1:0]        pend_tick_o,
  output logic [1:0]        pend_sv_o,
  output logic              pend_nmi_o
);
  localparam int unsigned NBANK = 2;

  logic    hit, wr_hit, rd_hit;
  wr_cmd_t cmd;
  logic [DW-1:0] rd_word;

  assign hit    = req_i && (addr_i == REG_OFS);
  assign wr_hit = hit && we_i;
  assign rd_hit = hit && !we_i;

  icsr_wr_dec u_dec (
    .wr_i        (wr_hit),
    .wdata_i     (wdata_i),
    .nmi_to_ns_i (nmi_to_ns_i),
    .v8_mode_i   (v8_mode_i),
    .cmd_o       (cmd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (secure_i == (b == 1));

    icsr_pend_bit u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  ((cmd.tick_set && sel) || hw_tick_set_i[b]),
      .clr_i  ((cmd.tick_clr && sel) || ack_tick_i[b]),
      .q_o    (pend_tick_o[b])
    );

    icsr_pend_bit u_sv (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (cmd.sv_set && sel),
      .clr_i  ((cmd.sv_clr && sel) || ack_sv_i[b]),
      .q_o    (pend_sv_o[b])
    );
  end

  icsr_pend_bit u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cmd.nmi_set || hw_nmi_set_i),
    .clr_i  (cmd.nmi_clr || ack_nmi_i),
    .q_o    (pend_nmi_o)
  );

  icsr_rd_mux #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_rd (
    .active_vec_i (active_vec_i),
    .pend_vec_i   (pend_vec_i),
    .num_active_i (num_active_i),
    .tick_i       (pend_tick_o),
    .sv_i         (pend_sv_o),
    .nmi_i        (pend_nmi_o),
    .secure_i     (secure_i),
    .nmi_to_ns_i  (nmi_to_ns_i),
    .word_o       (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_hit ? rd_word : '0;
  end

  a_r4_nmi_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !nmi_to_ns_i) |=> !rdata_o[31]);

  a_r5_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & RSV_MASK) == '0);

  a_r6_sv_set_secure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && secure_i && wdata_i[28] && !wdata_i[27] && !ack_sv_i[1])
    |=> pend_sv_o[1]);

  a_r8_nmi_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !nmi_to_ns_i && !hw_nmi_set_i && !ack_nmi_i)
    |=> $stable(pend_nmi_o));

  a_r9_clr_needs_v8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !v8_mode_i && !wdata_i[31] && !hw_nmi_set_i && !ack_nmi_i)
    |=> $stable(pend_nmi_o));

  a_r11_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_nmi_set_i |=> pend_nmi_o);
endmodule

// File: tb/tb_sec_icsr.sv
module tb_sec_icsr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [11:0] addr = 12'hD04;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cfg = 1'b0, v8 = 1'b1;
  logic [8:0]  act_v = 9'h003, pnd_v = 9'h00F;
  logic [3:0]  nact = 4'd1;
  logic [1:0]  hw_tick = '0, ack_tick = '0, ack_sv = '0;
  logic        hw_nmi = 1'b0, ack_nmi = 1'b0;
  logic [1:0]  p_tick, p_sv;
  logic        p_nmi;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  sec_icsr dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .secure_i(sec), .rdata_o(rdata),
    .nmi_to_ns_i(cfg), .v8_mode_i(v8), .active_vec_i(act_v),
    .pend_vec_i(pnd_v), .num_active_i(nact), .hw_tick_set_i(hw_tick),
    .hw_nmi_set_i(hw_nmi), .ack_tick_i(ack_tick), .ack_sv_i(ack_sv),
    .ack_nmi_i(ack_nmi), .pend_tick_o(p_tick), .pend_sv_o(p_sv),
    .pend_nmi_o(p_nmi)
  );

  // {secure, cfg, v8, wdata, expected {nmi, sv_s, sv_ns, tick_s, tick_ns}}
  localparam logic [39:0] VEC [14] = '{
    {1'b1, 1'b0, 1'b1, 32'h1000_0000, 5'b01000},
    {1'b0, 1'b0, 1'b1, 32'h0400_0000, 5'b01001},
    {1'b0, 1'b0, 1'b1, 32'h8000_0000, 5'b01001},
    {1'b0, 1'b1, 1'b1, 32'h8000_0000, 5'b11001},
    {1'b1, 1'b1, 1'b0, 32'h4000_0000, 5'b11001},
    {1'b1, 1'b1, 1'b1, 32'h4000_0000, 5'b01001},
    {1'b0, 1'b1, 1'b1, 32'hC000_0000, 5'b11001},
    {1'b1, 1'b0, 1'b1, 32'h1800_0000, 5'b11001},
    {1'b1, 1'b0, 1'b1, 32'h0800_0000, 5'b10001},
    {1'b0, 1'b0, 1'b1, 32'h0200_0000, 5'b10000},
    {1'b1, 1'b0, 1'b1, 32'h0600_0000, 5'b10000},
    {1'b1, 1'b0, 1'b1, 32'h0400_0000, 5'b10010},
    {1'b0, 1'b0, 1'b1, 32'h4000_0000, 5'b10010},
    {1'b0, 1'b1, 1'b1, 32'h01FF_FFFF, 5'b10010}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pend_state();
    return {27'd0, p_nmi, p_sv, p_tick};
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic bus_write(input logic s, input logic c, input logic m,
                           input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; sec = s; cfg = c; v8 = m; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; addr = 12'hD04;
  endtask

  task automatic bus_read(input logic s, input logic c, input logic [11:0] a,
                          output logic [31:0] d);
    req = 1'b1; we = 1'b0; sec = s; cfg = c; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0; addr = 12'hD04;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R1 pending in reset", pend_state(), 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pending after reset", pend_state(), 32'd0);

    for (int i = 0; i < 14; i++) begin
      bus_write(VEC[i][39], VEC[i][38], VEC[i][37], 12'hD04, VEC[i][36:5]);
      check($sformatf("vector %0d (R6,R7,R8,R9,R10)", i), pend_state(),
            {27'd0, VEC[i][4:0]});
    end
    // state now: nmi=1, tick_s=1

    bus_read(1'b1, 1'b1, 12'hD04, rd);
    check("R3 R4 secure read", rd, 32'h8400_F803);
    bus_read(1'b0, 1'b1, 12'hD04, rd);
    check("R3 non-secure read", rd, 32'h8000_F803);
    bus_read(1'b0, 1'b0, 12'hD04, rd);
    check("R4 nmi hidden", rd, 32'h0000_F803);
    @(negedge clk);
    check("R2 rdata zero when idle", rdata, 32'd0);

    nact = 4'd2;
    act_v = 9'h1A5; pnd_v = 9'h0C2;
    bus_read(1'b1, 1'b0, 12'hD04, rd);
    check("R2 fields, no base flag", rd, 32'h040C_21A5);
    nact = 4'd1; act_v = 9'h003; pnd_v = 9'h00F;

    bus_read(1'b1, 1'b1, 12'hD08, rd);
    check("R2 other offset reads 0", rd, 32'd0);
    bus_write(1'b0, 1'b1, 1'b1, 12'hD08, 32'hFFFF_FFFF);
    check("R10 other offset write ignored", pend_state(), 32'h0000_0012);
    bus_read(1'b1, 1'b1, 12'hD04, rd);
    check("R10 read leaves state", pend_state(), 32'h0000_0012);

    bus_write(1'b0, 1'b1, 1'b1, 12'hD04, 32'h1400_0000);
    check("R6 R7 non-secure set", pend_state(), 32'h0000_0017);
    bus_read(1'b0, 1'b1, 12'hD04, rd);
    check("R3 non-secure full read", rd, 32'h9400_F803);
    check("R5 reserved bits zero", rd & 32'h6BE0_0000, 32'd0);

    hw_nmi = 1'b1;
    bus_write(1'b1, 1'b1, 1'b1, 12'hD04, 32'h4000_0000);
    hw_nmi = 1'b0;
    check("R11 hw set beats sw clear", pend_state(), 32'h0000_0017);

    ack_nmi = 1'b1;
    @(negedge clk);
    ack_nmi = 1'b0;
    check("R11 nmi ack", pend_state(), 32'h0000_0007);

    hw_tick = 2'b01;
    bus_write(1'b0, 1'b1, 1'b1, 12'hD04, 32'h0200_0000);
    hw_tick = 2'b00;
    check("R11 hw tick beats sw clear", pend_state(), 32'h0000_0007);

    ack_tick = 2'b11; ack_sv = 2'b01;
    @(negedge clk);
    ack_tick = 2'b00; ack_sv = 2'b00;
    check("R11 acks clear", pend_state(), 32'd0);

    cfg = 1'b0; hw_nmi = 1'b1;
    @(negedge clk);
    hw_nmi = 1'b0;
    check("R11 hw nmi set ungated", pend_state(), 32'h0000_0010);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule